// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Stall Control

This block is the hazard controller of a five-stage in-order RISC pipeline (fetch, decode, execute, memory, write-back). It looks only at register numbers and control flags held in the pipeline registers and produces two results. The first is a pair of 2-bit select codes that steer each ALU operand mux in the execute stage. Each select picks either the register-file value, the result in the memory stage, or the result in the write-back stage. The second is a set of stall controls that freeze the program counter and the decode register while a bubble is pushed into the execute stage.

A stall is requested in two cases. The first is an instruction in decode that needs a value a load in execute has not fetched yet. The second is a branch compared in decode whose operand is still in flight. For that branch the stall lasts one cycle when the producer is an ALU instruction and two cycles when it is a load. The block is purely combinational. The datapath registers that hold its inputs advance under its stall outputs, so stall lengths come from how the inputs change between cycles.

Top module: `hzd_unit`

## Requirements
- R1: Each operand select takes only the codes 2'b00 (register file), 2'b01 (write-back stage result) or 2'b10 (memory stage result); 2'b11 never appears.
- R2: A select is 2'b10 when the memory stage writes a register (`mem_reg_write`=1), its destination is non-zero and equals the operand's source (`ex_rs` for select A, `ex_rt` for select B).
- R3: A select is 2'b01 when the write-back stage writes a non-zero destination equal to the operand's source and R2 does not apply.
- R4: When the memory and write-back stages both match an operand, the memory stage (younger) result wins with 2'b10.
- R5: A stage whose write flag is low, or whose destination is register 0, never causes forwarding or a stall.
- R6: A load-use hazard (execute stage has `ex_mem_read`=1, `ex_reg_write`=1, non-zero `ex_dst` equal to `id_rs` or `id_rt`) requests a stall, whether or not decode holds a branch.
- R7: Stall outputs move together: while stalling, `pc_write`=0, `ifid_write`=0 and `idex_bubble`=1; otherwise 1, 1, 0.
- R8: A branch in decode (`id_branch`=1) reading the non-zero destination of a writing instruction in execute stalls; once that ALU producer reaches the memory stage, no stall remains, so an ALU producer costs one cycle.
- R9: A branch in decode reading the non-zero destination of a load in the memory stage (`mem_mem_read`=1, `mem_reg_write`=1) also stalls, so a load producer costs two cycles.
- R10: A non-branch instruction in decode is never stalled by a producer in the memory or write-back stage, nor by a non-load producer in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register of the instruction in execute |
| ex_rt | input | 5 | Second source register of the instruction in execute |
| ex_dst | input | 5 | Destination register of the instruction in execute |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | 5 | Destination register in the memory stage |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | 5 | Destination register in the write-back stage |
| wb_reg_write | input | 1 | Write-back-stage instruction writes a register |
| id_rs | input | 5 | First source register of the instruction in decode |
| id_rt | input | 5 | Second source register of the instruction in decode |
| id_branch | input | 1 | Decode holds a branch compared in decode |
| fwd_a | output | 2 | Operand A select |
| fwd_b | output | 2 | Operand B select |
| pc_write | output | 1 | Program counter update enable |
| ifid_write | output | 1 | Decode pipeline register update enable |
| idex_bubble | output | 1 | Clear the control fields entering execute |

## Verification
The assertions assume that a stage flagged as a load also has its write flag set. The bench keeps to this: whenever it draws a load flag at random, it forces the matching write flag high. Register numbers are drawn from a narrow range that includes register 0, so matches, double matches and zero-destination cases all occur often. Directed sequences step a producer through execute, memory and write-back beside a waiting branch, and count the stall cycles for ALU and load producers.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int REG_AW = 5;
  localparam int NUM_OPS = 2;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwd_sel_e;

  // A producing stage supplies a register when it writes, the target is not r0,
  // and the target equals the consumer's source.
  function automatic logic supplies(input logic wr,
                                    input logic [REG_AW-1:0] dst,
                                    input logic [REG_AW-1:0] src);
    return wr && (dst != '0) && (dst == src);
  endfunction
endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
  import hzd_pkg::*;
(
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr,
  output logic [1:0]        sel
);
  logic from_mem, from_wb;

  assign from_mem = supplies(mem_wr, mem_dst, src);
  assign from_wb  = supplies(wb_wr, wb_dst, src);

  always_comb begin
    if (from_mem)     sel = SEL_MEM;
    else if (from_wb) sel = SEL_WB;
    else              sel = SEL_RF;
  end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use
  import hzd_pkg::*;
(
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  output logic              hit
);
  assign hit = ex_load && (supplies(ex_wr, ex_dst, id_rs) ||
                           supplies(ex_wr, ex_dst, id_rt));
endmodule

// File: rtl/hzd_branch_dep.sv
module hzd_branch_dep
  import hzd_pkg::*;
(
  input  logic              id_branch,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr,
  input  logic              mem_load,
  output logic              hit_ex,
  output logic              hit_mem_load
);
  logic ex_dep, mem_dep;

  assign ex_dep  = supplies(ex_wr, ex_dst, id_rs) || supplies(ex_wr, ex_dst, id_rt);
  assign mem_dep = supplies(mem_wr, mem_dst, id_rs) || supplies(mem_wr, mem_dst, id_rt);

  // Any producer still in execute blocks the decode-stage compare.
  assign hit_ex = id_branch && ex_dep;
  // A load in the memory stage has no data until write-back.
  assign hit_mem_load = id_branch && mem_load && mem_dep;
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
(
  input  logic [4:0] ex_rs,
  input  logic [4:0] ex_rt,
  input  logic [4:0] ex_dst,
  input  logic       ex_reg_write,
  input  logic       ex_mem_read,
  input  logic [4:0] mem_dst,
  input  logic       mem_reg_write,
  input  logic       mem_mem_read,
  input  logic [4:0] wb_dst,
  input  logic       wb_reg_write,
  input  logic [4:0] id_rs,
  input  logic [4:0] id_rt,
  input  logic       id_branch,
  output logic [1:0] fwd_a,
  output logic [1:0] fwd_b,
  output logic       pc_write,
  output logic       ifid_write,
  output logic       idex_bubble
);
  logic [REG_AW-1:0] op_src [NUM_OPS];
  logic [1:0]        op_sel [NUM_OPS];

  // Named events for the checker.
  logic lu_hit;
  logic br_ex_hit;
  logic br_mem_hit;
  logic stall;

  assign op_src[0] = ex_rs;
  assign op_src[1] = ex_rt;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hzd_fwd_pick u_pick (
      .src     (op_src[g]),
      .mem_dst (mem_dst),
      .mem_wr  (mem_reg_write),
      .wb_dst  (wb_dst),
      .wb_wr   (wb_reg_write),
      .sel     (op_sel[g])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  hzd_load_use u_lu (
    .ex_dst  (ex_dst),
    .ex_wr   (ex_reg_write),
    .ex_load (ex_mem_read),
    .id_rs   (id_rs),
    .id_rt   (id_rt),
    .hit     (lu_hit)
  );

  hzd_branch_dep u_br (
    .id_branch    (id_branch),
    .id_rs        (id_rs),
    .id_rt        (id_rt),
    .ex_dst       (ex_dst),
    .ex_wr        (ex_reg_write),
    .mem_dst      (mem_dst),
    .mem_wr       (mem_reg_write),
    .mem_load     (mem_mem_read),
    .hit_ex       (br_ex_hit),
    .hit_mem_load (br_mem_hit)
  );

  assign stall       = lu_hit || br_ex_hit || br_mem_hit;
  assign pc_write    = !stall;
  assign ifid_write  = !stall;
  assign idex_bubble = stall;
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk (
  input logic [4:0] ex_rs,
  input logic [4:0] ex_rt,
  input logic [4:0] ex_dst,
  input logic       ex_reg_write,
  input logic       ex_mem_read,
  input logic [4:0] mem_dst,
  input logic       mem_reg_write,
  input logic       mem_mem_read,
  input logic [4:0] wb_dst,
  input logic       wb_reg_write,
  input logic [4:0] id_rs,
  input logic [4:0] id_rt,
  input logic       id_branch,
  input logic [1:0] fwd_a,
  input logic [1:0] fwd_b,
  input logic       pc_write,
  input logic       ifid_write,
  input logic       idex_bubble,
  input logic       lu_hit,
  input logic       br_ex_hit,
  input logic       br_mem_hit
);
  always_comb begin
    p_sel_legal_r1: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    if (mem_reg_write && mem_dst != 5'd0 && mem_dst == ex_rs)
      p_mem_wins_a_r4: assert (fwd_a == 2'b10);
    if (mem_reg_write && mem_dst != 5'd0 && mem_dst == ex_rt)
      p_mem_wins_b_r2: assert (fwd_b == 2'b10);
    if (fwd_a == 2'b01)
      p_wb_source_r3: assert (wb_reg_write && wb_dst == ex_rs && wb_dst != 5'd0);
    if (!mem_reg_write && !wb_reg_write)
      p_no_writer_r5: assert (fwd_a == 2'b00 && fwd_b == 2'b00);
    p_stall_group_r7: assert (pc_write == ifid_write && idex_bubble == !pc_write);
    if (lu_hit)
      p_load_use_r6: assert (idex_bubble);
    if (br_mem_hit)
      p_branch_load_r9: assert (!pc_write && id_branch && mem_mem_read);
    if (br_ex_hit)
      p_branch_alu_r8: assert (!ifid_write);
    if (!id_branch && !ex_mem_read)
      p_no_stall_r10: assert (pc_write);
  end
endmodule

bind hzd_unit hzd_unit_chk u_chk (
  .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_dst(ex_dst),
  .ex_reg_write(ex_reg_write), .ex_mem_read(ex_mem_read),
  .mem_dst(mem_dst), .mem_reg_write(mem_reg_write), .mem_mem_read(mem_mem_read),
  .wb_dst(wb_dst), .wb_reg_write(wb_reg_write),
  .id_rs(id_rs), .id_rt(id_rt), .id_branch(id_branch),
  .fwd_a(fwd_a), .fwd_b(fwd_b),
  .pc_write(pc_write), .ifid_write(ifid_write), .idex_bubble(idex_bubble),
  .lu_hit(lu_hit), .br_ex_hit(br_ex_hit), .br_mem_hit(br_mem_hit)
);

// File: tb/sim_hzd_unit.sv
module sim_hzd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 3000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0] ex_rs, ex_rt, ex_dst, mem_dst, wb_dst, id_rs, id_rt;
  logic ex_reg_write, ex_mem_read, mem_reg_write, mem_mem_read, wb_reg_write, id_branch;
  logic [1:0] fwd_a, fwd_b;
  logic pc_write, ifid_write, idex_bubble;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  hzd_unit u0 (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_dst(ex_dst),
    .ex_reg_write(ex_reg_write), .ex_mem_read(ex_mem_read),
    .mem_dst(mem_dst), .mem_reg_write(mem_reg_write), .mem_mem_read(mem_mem_read),
    .wb_dst(wb_dst), .wb_reg_write(wb_reg_write),
    .id_rs(id_rs), .id_rt(id_rt), .id_branch(id_branch),
    .fwd_a(fwd_a), .fwd_b(fwd_b),
    .pc_write(pc_write), .ifid_write(ifid_write), .idex_bubble(idex_bubble)
  );

  // Bench model: which code an operand should get.
  function automatic logic [1:0] want_sel(input logic [4:0] src);
    logic [1:0] r;
    r = 2'b00;
    if (src != 5'd0) begin
      if (wb_reg_write && wb_dst == src) r = 2'b01;
      if (mem_reg_write && mem_dst == src) r = 2'b10;
    end
    return r;
  endfunction

  function automatic logic reads(input logic [4:0] d);
    return d != 5'd0 && (d == id_rs || d == id_rt);
  endfunction

  function automatic logic want_stall();
    logic s;
    s = 1'b0;
    if (ex_reg_write && ex_mem_read && reads(ex_dst)) s = 1'b1;
    if (id_branch) begin
      if (ex_reg_write && reads(ex_dst)) s = 1'b1;
      if (mem_reg_write && mem_mem_read && reads(mem_dst)) s = 1'b1;
    end
    return s;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    ex_rs = 0; ex_rt = 0; ex_dst = 0; ex_reg_write = 0; ex_mem_read = 0;
    mem_dst = 0; mem_reg_write = 0; mem_mem_read = 0;
    wb_dst = 0; wb_reg_write = 0; id_rs = 0; id_rt = 0; id_branch = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic check_stall(input string req, input logic exp);
    check(req, "pc_write", pc_write, !exp);
    check("R7", "ifid_write", ifid_write, !exp);
    check("R7", "idex_bubble", idex_bubble, exp);
  endtask

  task automatic check_all(input string req);
    check(req, "fwd_a", fwd_a, want_sel(ex_rs));
    check(req, "fwd_b", fwd_b, want_sel(ex_rt));
    check_stall(req, want_stall());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    clear_all();
    @(posedge clk);
    settle();
    // Idle state: nothing forwarded, nothing stalled (R1, R7)
    check("R1", "fwd_a idle", fwd_a, 0);
    check("R1", "fwd_b idle", fwd_b, 0);
    check_stall("R7", 1'b0);

    // R2: memory-stage forwarding on A and B
    @(posedge clk); clear_all();
    ex_rs = 5'd7; ex_rt = 5'd9; mem_dst = 5'd7; mem_reg_write = 1;
    settle(); check("R2", "fwd_a mem", fwd_a, 2); check("R2", "fwd_b none", fwd_b, 0);
    @(posedge clk); mem_dst = 5'd9;
    settle(); check("R2", "fwd_b mem", fwd_b, 2); check("R2", "fwd_a none", fwd_a, 0);

    // R3: write-back forwarding
    @(posedge clk); clear_all();
    ex_rs = 5'd3; ex_rt = 5'd3; wb_dst = 5'd3; wb_reg_write = 1;
    settle(); check("R3", "fwd_a wb", fwd_a, 1); check("R3", "fwd_b wb", fwd_b, 1);

    // R4: both match, memory stage wins
    @(posedge clk); mem_dst = 5'd3; mem_reg_write = 1;
    settle(); check("R4", "fwd_a prio", fwd_a, 2); check("R4", "fwd_b prio", fwd_b, 2);

    // R5: register 0 and write flag low are ignored
    @(posedge clk); clear_all();
    ex_rs = 0; ex_rt = 0; mem_dst = 0; mem_reg_write = 1; wb_dst = 0; wb_reg_write = 1;
    settle(); check("R5", "fwd_a r0", fwd_a, 0); check("R5", "fwd_b r0", fwd_b, 0);
    @(posedge clk); clear_all();
    ex_rs = 5'd4; mem_dst = 5'd4; wb_dst = 5'd4;
    ex_dst = 5'd4; ex_mem_read = 1; id_rs = 5'd4;
    settle(); check("R5", "fwd_a no write", fwd_a, 0); check_stall("R5", 1'b0);

    // R6: load-use on rs and on rt
    @(posedge clk); clear_all();
    ex_dst = 5'd6; ex_reg_write = 1; ex_mem_read = 1; id_rs = 5'd6;
    settle(); check_stall("R6", 1'b1);
    @(posedge clk); id_rs = 5'd1; id_rt = 5'd6;
    settle(); check_stall("R6", 1'b1);
    @(posedge clk); id_rt = 5'd2;
    settle(); check_stall("R6", 1'b0);

    // R8: ALU producer before branch costs one cycle
    begin
      int stalls = 0;
      @(posedge clk); clear_all();
      id_branch = 1; id_rs = 5'd10; ex_dst = 5'd10; ex_reg_write = 1;
      settle(); if (!pc_write) stalls++;
      @(posedge clk); clear_all();
      id_branch = 1; id_rs = 5'd10; mem_dst = 5'd10; mem_reg_write = 1;
      settle(); if (!pc_write) stalls++;
      check("R8", "alu-branch stall cycles", stalls, 1);
    end

    // R9: load producer before branch costs two cycles
    begin
      int stalls = 0;
      @(posedge clk); clear_all();
      id_branch = 1; id_rt = 5'd11; ex_dst = 5'd11; ex_reg_write = 1; ex_mem_read = 1;
      settle(); if (!pc_write) stalls++;
      @(posedge clk); clear_all();
      id_branch = 1; id_rt = 5'd11; mem_dst = 5'd11; mem_reg_write = 1; mem_mem_read = 1;
      settle(); if (!pc_write) stalls++;
      @(posedge clk); clear_all();
      id_branch = 1; id_rt = 5'd11; wb_dst = 5'd11; wb_reg_write = 1;
      settle(); if (!pc_write) stalls++;
      check("R9", "load-branch stall cycles", stalls, 2);
    end

    // R10: non-branch consumer not stalled by ALU in EX or load in MEM
    @(posedge clk); clear_all();
    id_rs = 5'd12; ex_dst = 5'd12; ex_reg_write = 1;
    settle(); check_stall("R10", 1'b0);
    @(posedge clk); clear_all();
    id_rs = 5'd12; mem_dst = 5'd12; mem_reg_write = 1; mem_mem_read = 1;
    settle(); check_stall("R10", 1'b0);

    // Random mix over a narrow register range (R1..R10 together)
    for (int i = 0; i < N_RAND; i++) begin
      @(posedge clk);
      ex_rs = 5'($urandom_range(0, 3)); ex_rt = 5'($urandom_range(0, 3));
      ex_dst = 5'($urandom_range(0, 3)); mem_dst = 5'($urandom_range(0, 3));
      wb_dst = 5'($urandom_range(0, 3));
      id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3));
      ex_mem_read = 1'($urandom_range(0, 1));
      ex_reg_write = ex_mem_read | 1'($urandom_range(0, 1));
      mem_mem_read = 1'($urandom_range(0, 1));
      mem_reg_write = mem_mem_read | 1'($urandom_range(0, 1));
      wb_reg_write = 1'($urandom_range(0, 1));
      id_branch = 1'($urandom_range(0, 1));
      settle();
      check_all("R1-mix");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule